// File: doc/BRIEF.md
# Memory Built-In Self-Test Engine

This block is a self-test controller for a word-addressed memory with 32-bit words. A single start pulse runs four test phases in a fixed order. Each phase first writes its whole sequence of addresses and values. It then resets its pattern source and replays the same sequence as reads, comparing every returned word against the regenerated value. Expected data is never stored.

The first two phases write alternating-bit constants over a small window. The third phase walks addresses upward and writes values from a 32-bit linear-congruential generator. The fourth phase scatters its writes with a 16-bit linear-congruential address generator, and each word holds its loop index. Two saturating counters record the words written and the words that failed their compare. When the run finishes, done is raised together with a pass flag. Phase lengths are parameters, so a shortened run can be used for simulation. The generator recurrences do not change with the lengths.

Top module: `mbist_engine`

## Requirements
- R1: After reset, busy, done, pass, mem_req and both counters are 0.
- R2: Phase 1 writes 32'hAAAAAAAA to word addresses 0 to P1_LEN-1 in increasing order.
- R3: Phase 2 writes 32'h55555555 to word addresses 0 to P2_LEN-1 in increasing order.
- R4: Phase 3 writes addresses 0 to P3_LEN-1 in increasing order. The value is the state s of s' = 1664525*s + 1013904223 mod 2^32, starting from s = 0 and taken after each update.
- R5: Phase 4 makes P4_LEN writes. Write k goes to the address given by a = 25173*a + 13849 mod 2^16, starting from a = 0 and updated before use, and its data is k zero-extended to 32 bits.
- R6: After the writes of a phase, the phase reads back the identical address sequence. Each returned word that differs from the regenerated value adds 1 to bad_words.
- R7: total_words adds 1 for every accepted write, so a complete run ends with P1_LEN+P2_LEN+P3_LEN+P4_LEN. A new start clears both counters.
- R8: With mem_ready held high, done goes to 1 exactly 2*(P1_LEN+P2_LEN+P3_LEN+P4_LEN)+2 clock edges after the edge that samples start. pass is 1 only if bad_words is 0, and busy is 0 while done is 1.
- R9: While mem_req is 1 and mem_ready is 0, mem_addr, mem_wdata and mem_we keep their values into the next cycle.
- R10: A read is accepted on an edge where mem_req=1, mem_we=0 and mem_ready=1. mem_rdata is compared on the following edge.
- R11: Both counters stop at 2^CNT_W-1 and do not wrap.
- R12: A start pulse while busy is 1 has no effect on the run, its timing or its counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished; cleared by the next start |
| pass | output | 1 | Last run had no mismatches |
| total_words | output | CNT_W | Saturating count of accepted writes |
| bad_words | output | CNT_W | Saturating count of mismatched reads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after an accepted read |

## Verification
The run is one request per cycle when mem_ready is high. The bench therefore counts negative edges from the edge that samples start and expects done on edge 2*(sum of lengths)+2 and not one edge earlier. A mid-run start must leave that count unchanged. The memory model returns read data on the edge after acceptance, which is the one-cycle latency the compare expects. Any mistake in the read path therefore shows up as mismatches on a fault-free run. Counters, pass and the logged write and read sequences are sampled at a negative edge once done is seen. Every comparison is made against sequences and fault hit counts that the bench computes from the recurrences on its own.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_DRAIN,
    ST_FIN
  } mbist_st_t;

  localparam logic [31:0] PAT_ALT_HI = 32'hAAAA_AAAA;
  localparam logic [31:0] PAT_ALT_LO = 32'h5555_5555;
endpackage

// File: rtl/mbist_lcg.sv
// Linear-congruential sequence source; value holds the state after the
// latest update, so a reseed loads the first value reached from seed zero.
module mbist_lcg #(
  parameter int          W   = 32,
  parameter logic [W-1:0] MUL = '0,
  parameter logic [W-1:0] INC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reseed,
  input  logic         step,
  output logic [W-1:0] value
);
  logic [W-1:0] nxt;
  assign nxt = MUL * value + INC;

  always_ff @(posedge clk) begin
    if (rst || reseed) value <= INC;
    else if (step)     value <= nxt;
  end
endmodule

// File: rtl/mbist_sat_ctr.sv
module mbist_sat_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr)            q <= '0;
    else if (inc && q != '1)   q <= q + 1'b1;
  end
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
  import mbist_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 32,
  parameter int P1_LEN = 256,
  parameter int P2_LEN = 256,
  parameter int P3_LEN = 1048576,
  parameter int P4_LEN = 65536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [CNT_W-1:0]  total_words,
  output logic [CNT_W-1:0]  bad_words,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata
);
  localparam int MAX12  = (P1_LEN > P2_LEN) ? P1_LEN : P2_LEN;
  localparam int MAX34  = (P3_LEN > P4_LEN) ? P3_LEN : P4_LEN;
  localparam int MAXLEN = (MAX12 > MAX34) ? MAX12 : MAX34;
  localparam int IDX_W  = (MAXLEN > 2) ? $clog2(MAXLEN) : 1;

  mbist_st_t        state;
  logic [1:0]       phase;
  logic [IDX_W-1:0] idx;
  int               cur_len;
  logic             accept, last, start_go, reseed;
  logic [31:0]      lcg_data;
  logic [15:0]      lcg_addr;
  logic [31:0]      pattern, exp_q;
  logic             rd_pend, mismatch;

  assign busy     = (state != ST_IDLE);
  assign mem_req  = (state == ST_WR) || (state == ST_RD);
  assign mem_we   = (state == ST_WR);
  assign accept   = mem_req && mem_ready;
  assign start_go = start && (state == ST_IDLE);

  always_comb begin
    case (phase)
      2'd0:    cur_len = P1_LEN;
      2'd1:    cur_len = P2_LEN;
      2'd2:    cur_len = P3_LEN;
      default: cur_len = P4_LEN;
    endcase
  end

  assign last   = (idx == IDX_W'(cur_len - 1));
  assign reseed = start_go || (accept && last);

  mbist_lcg #(.W(32), .MUL(32'd1664525), .INC(32'd1013904223)) u_data_gen (
    .clk(clk), .rst(rst), .reseed(reseed),
    .step(accept && phase == 2'd2), .value(lcg_data)
  );

  mbist_lcg #(.W(16), .MUL(16'd25173), .INC(16'd13849)) u_addr_gen (
    .clk(clk), .rst(rst), .reseed(reseed),
    .step(accept && phase == 2'd3), .value(lcg_addr)
  );

  always_comb begin
    case (phase)
      2'd0:    pattern = PAT_ALT_HI;
      2'd1:    pattern = PAT_ALT_LO;
      2'd2:    pattern = lcg_data;
      default: pattern = 32'(idx);
    endcase
  end

  assign mem_addr  = (phase == 2'd3) ? ADDR_W'(lcg_addr) : ADDR_W'(idx);
  assign mem_wdata = pattern;

  // Read compare stage: the expected word is captured with the request and
  // checked against the data that arrives on the following edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      exp_q   <= '0;
    end else begin
      rd_pend <= accept && !mem_we;
      if (accept) exp_q <= pattern;
    end
  end

  assign mismatch = rd_pend && (mem_rdata != exp_q);

  mbist_sat_ctr #(.W(CNT_W)) u_total_ctr (
    .clk(clk), .rst(rst), .clr(start_go), .inc(accept && mem_we), .q(total_words)
  );

  mbist_sat_ctr #(.W(CNT_W)) u_bad_ctr (
    .clk(clk), .rst(rst), .clr(start_go), .inc(mismatch), .q(bad_words)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      phase <= 2'd0;
      idx   <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_WR;
            phase <= 2'd0;
            idx   <= '0;
            done  <= 1'b0;
            pass  <= 1'b0;
          end
        end
        ST_WR: begin
          if (accept) begin
            if (last) begin
              idx   <= '0;
              state <= ST_RD;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_RD: begin
          if (accept) begin
            if (last) begin
              idx <= '0;
              if (phase == 2'd3) begin
                state <= ST_DRAIN;
              end else begin
                phase <= phase + 2'd1;
                state <= ST_WR;
              end
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DRAIN: state <= ST_FIN;
        ST_FIN: begin
          done  <= 1'b1;
          pass  <= (bad_words == '0);
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
  parameter int ADDR_W = 20,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [CNT_W-1:0]  total_words,
  input logic [CNT_W-1:0]  bad_words,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_we))); // R9

  AST_TOTAL_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    busy |=> (total_words >= $past(total_words))); // R12

  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && pass) |-> (bad_words == '0)); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !mem_req)); // R8

  AST_BAD_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    bad_words <= total_words); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (total_words == '1) |=> (total_words == '1 || $past(!busy))); // R11
endmodule

bind mbist_engine mbist_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .pass(pass),
  .total_words(total_words), .bad_words(bad_words), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/mbist_engine_test.sv
`timescale 1ns/1ps
module mbist_engine_test;
  localparam int AW = 16;
  localparam int L1 = 8, L2 = 8, L3 = 16, L4 = 16;
  localparam int SUM = L1 + L2 + L3 + L4;
  localparam int LOGN = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic busy, done, pass;
  logic [31:0] total_words, bad_words;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic mem_ready = 1'b1;

  logic s_busy, s_done, s_pass, s_req, s_we;
  logic [4:0] s_total, s_bad;
  logic [AW-1:0] s_addr;
  logic [31:0] s_wdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  bit stall_on = 0, fault_on = 0;
  logic [AW-1:0] fault_addr = '0;
  int hold_viol = 0;

  logic [31:0] ram  [0:65535];
  logic [31:0] gold [0:65535];
  logic [AW-1:0] wl_a [0:LOGN-1];
  logic [31:0]   wl_d [0:LOGN-1];
  logic [AW-1:0] rl_a [0:LOGN-1];
  int wr_n = 0, rd_n = 0;
  logic [AW-1:0] ex_a [0:LOGN-1];
  logic [31:0]   ex_d [0:LOGN-1];

  always #2 clk = ~clk;

  mbist_engine #(.ADDR_W(AW), .CNT_W(32), .P1_LEN(L1), .P2_LEN(L2), .P3_LEN(L3), .P4_LEN(L4)) uut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
    .total_words(total_words), .bad_words(bad_words), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  // Narrow-counter copy reading all zeros: nearly every compare fails.
  mbist_engine #(.ADDR_W(AW), .CNT_W(5), .P1_LEN(L1), .P2_LEN(L2), .P3_LEN(L3), .P4_LEN(L4)) uut_sat (
    .clk(clk), .rst(rst), .start(start), .busy(s_busy), .done(s_done), .pass(s_pass),
    .total_words(s_total), .bad_words(s_bad), .mem_req(s_req), .mem_we(s_we),
    .mem_addr(s_addr), .mem_wdata(s_wdata), .mem_ready(1'b1), .mem_rdata(32'h0)
  );

  // Behavioural RAM: read data appears on the edge after acceptance.
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        ram[mem_addr] <= mem_wdata;
        if (wr_n < LOGN) begin wl_a[wr_n] = mem_addr; wl_d[wr_n] = mem_wdata; end
        wr_n = wr_n + 1;
      end else begin
        mem_rdata <= ram[mem_addr] ^ ((fault_on && mem_addr == fault_addr) ? 32'h1 : 32'h0);
        if (rd_n < LOGN) rl_a[rd_n] = mem_addr;
        rd_n = rd_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic int fault_hits(input logic [AW-1:0] fa);
    int n = 0;
    logic [15:0] a = 16'd0;
    if (fa < L1) n++;
    if (fa < L2) n++;
    if (fa < L3) n++;
    for (int k = 0; k < L4; k++) begin
      a = 16'(25173 * a + 13849);
      if (AW'(a) == fa) n++;
    end
    return n;
  endfunction

  task automatic build_expected();
    logic [31:0] s = 32'd0;
    logic [15:0] a = 16'd0;
    int p = 0;
    for (int i = 0; i < 65536; i++) gold[i] = 32'h0;
    for (int i = 0; i < L1; i++) begin ex_a[p] = AW'(i); ex_d[p] = 32'hAAAAAAAA; p++; end
    for (int i = 0; i < L2; i++) begin ex_a[p] = AW'(i); ex_d[p] = 32'h55555555; p++; end
    for (int i = 0; i < L3; i++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      ex_a[p] = AW'(i); ex_d[p] = s; p++;
    end
    for (int i = 0; i < L4; i++) begin
      a = 16'(25173 * a + 13849);
      ex_a[p] = AW'(a); ex_d[p] = 32'(i); p++;
    end
    for (int i = 0; i < SUM; i++) gold[ex_a[i]] = ex_d[i];
  endtask

  // Pulse start, count edges until done; optionally re-pulse start mid-run.
  task automatic run(input bit mid_start, output int cycles);
    wr_n = 0; rd_n = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    cycles = 0;
    for (int c = 1; c < 2000; c++) begin
      @(negedge clk);
      start = (mid_start && c == 30);
      if (done) begin cycles = c; break; end
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    chk(!busy && !done && !pass, "R1 flags", {busy, done, pass}, 0);
    chk(!mem_req, "R1 mem_req", mem_req, 0);
    chk(total_words == 0 && bad_words == 0, "R1 counters", total_words + bad_words, 0);
  endtask

  task automatic t_clean();
    int cyc, bad_seq, bad_rd, bad_img;
    stall_on = 0; fault_on = 0;
    for (int i = 0; i < 65536; i++) ram[i] = 32'h0;
    run(0, cyc);
    chk(cyc == 2 * SUM + 2, "R8 done latency", cyc, 2 * SUM + 2);
    chk(pass == 1'b1 && !busy, "R8 pass clean", pass, 1);
    chk(bad_words == 0, "R10 R6 clean compare", bad_words, 0);
    chk(total_words == SUM, "R7 total", total_words, SUM);
    bad_seq = 0;
    for (int i = 0; i < L1; i++) if (wl_a[i] !== ex_a[i] || wl_d[i] !== ex_d[i]) bad_seq++;
    chk(bad_seq == 0, "R2 phase1 writes", bad_seq, 0);
    bad_seq = 0;
    for (int i = L1; i < L1 + L2; i++) if (wl_a[i] !== ex_a[i] || wl_d[i] !== ex_d[i]) bad_seq++;
    chk(bad_seq == 0, "R3 phase2 writes", bad_seq, 0);
    bad_seq = 0;
    for (int i = L1 + L2; i < L1 + L2 + L3; i++) if (wl_a[i] !== ex_a[i] || wl_d[i] !== ex_d[i]) bad_seq++;
    chk(bad_seq == 0, "R4 phase3 writes", bad_seq, 0);
    bad_seq = 0;
    for (int i = L1 + L2 + L3; i < SUM; i++) if (wl_a[i] !== ex_a[i] || wl_d[i] !== ex_d[i]) bad_seq++;
    chk(bad_seq == 0, "R5 phase4 writes", bad_seq, 0);
    bad_rd = 0;
    for (int i = 0; i < SUM; i++) if (rl_a[i] !== ex_a[i]) bad_rd++;
    chk(rd_n == SUM && bad_rd == 0, "R6 read replay", bad_rd + rd_n, SUM);
    bad_img = 0;
    for (int i = 0; i < 65536; i++) if (ram[i] !== gold[i]) bad_img++;
    chk(bad_img == 0, "R4 R5 memory image", bad_img, 0);
    chk(s_total == 5'd31, "R11 total saturates", s_total, 31);
    chk(s_bad == 5'd31 && !s_pass, "R11 bad saturates", s_bad, 31);
  endtask

  task automatic t_stall_fault();
    int cyc, exp_bad;
    stall_on = 1; fault_on = 1; fault_addr = AW'(3); hold_viol = 0;
    exp_bad = fault_hits(fault_addr);
    run(0, cyc);
    stall_on = 0;
    chk(bad_words == exp_bad, "R6 fault count", bad_words, exp_bad);
    chk(pass == 1'b0 && done, "R8 fail flag", pass, 0);
    chk(total_words == SUM, "R7 total after restart", total_words, SUM);
    chk(hold_viol == 0, "R9 request hold", hold_viol, 0);
    chk(cyc > 2 * SUM + 2, "R9 stalls slow run", cyc, 2 * SUM + 3);
  endtask

  task automatic t_phase4_fault();
    int cyc;
    fault_on = 1; fault_addr = AW'(13849);
    run(0, cyc);
    fault_on = 0;
    chk(bad_words == fault_hits(fault_addr) && bad_words == 1, "R5 scrambled fault", bad_words, 1);
    chk(cyc == 2 * SUM + 2, "R8 latency fault run", cyc, 2 * SUM + 2);
  endtask

  task automatic t_busy_start();
    int cyc;
    run(1, cyc);
    chk(cyc == 2 * SUM + 2, "R12 timing unchanged", cyc, 2 * SUM + 2);
    chk(total_words == SUM && pass, "R12 counters unchanged", total_words, SUM);
  endtask

  // Ready pattern and request-hold monitor, sampled on the falling edge.
  initial begin
    bit pend = 0;
    logic [AW-1:0] pa; logic [31:0] pd; logic pw;
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (pend && (!mem_req || mem_addr !== pa || mem_wdata !== pd || mem_we !== pw)) hold_viol++;
      cnt++;
      mem_ready = stall_on ? (((cnt * 7) % 5) > 1) : 1'b1;
      pend = mem_req && !mem_ready;
      pa = mem_addr; pd = mem_wdata; pw = mem_we;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    build_expected();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_stall_fault();
    t_phase4_fault();
    t_busy_start();
    summary();
  end
endmodule